// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the slave-side protocol engine of a small two-wire (I2C) serial memory. It runs in a fast system clock domain and oversamples the SCL and SDA lines. It finds bus conditions (START, repeated START, STOP) on those lines, shifts bytes in and out, and drives an open-drain enable that pulls SDA low for acknowledge bits and for zero data bits. It holds a 256-byte array and a one-byte protection register.

A transfer opens with a select byte. That byte carries a type code, three chip-enable bits and a direction bit. One type code selects the array and a second type code selects the protection register. The slave answers only when the chip-enable bits match its strap inputs. The array supports byte and page writes, reads from the current pointer, random reads through a repeated START, and sequential reads. Writes can be refused by the write-control pin or by the protection register. A stored write starts a fixed-length busy period when the master sends STOP. During that period the slave does not answer its select byte.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset, `sda_oe` is low, the address pointer is 0x00, every array byte is 0x00 and the protection register is 0x00, so nothing is protected.
- R2: A fall of SDA while SCL is high is a START. A rise of SDA while SCL is high is a STOP. Data bits are sampled on the rising edge of SCL, most significant bit first. START or STOP ends any transfer in progress.
- R3: In the select byte, bits 7:4 are the type code, bits 3:1 are the chip-enable bits and bit 0 is the direction (1 = read, 0 = write). The slave acknowledges only if the type code is 1010b (array) or 0110b (protection register) and bits 3:1 equal `strap_ce`. Otherwise it leaves SDA alone until the next START.
- R4: An acknowledge is `sda_oe` high from just after the eighth falling SCL edge of a byte until just after the ninth falling edge. `sda_oe` changes only while SCL is low.
- R5: An array write is a select byte with direction 0, then an address byte, then data bytes. Each accepted byte is acknowledged, and each accepted data byte is stored at the pointer.
- R6: After each stored data byte, the low four bits of the pointer increment and wrap within the 16-byte row. The upper four bits of the pointer do not change.
- R7: A random read is a select byte with direction 0 and an address byte, then a repeated START and a select byte with direction 1. The first data byte returned is the one at that address.
- R8: While `wr_ctl` is high, a data byte is neither stored nor acknowledged. This applies to the array and to the protection register.
- R9: A write transfer to type 0110b stores its single data byte in the protection register. A read transfer to type 0110b returns that register. When bit 7 of the register is set, array rows whose address bits 7:4 are at or above register bits 3:0 are protected. A data byte aimed at a protected row is not stored and not acknowledged.
- R10: A STOP that ends a transfer in which at least one byte was stored starts a busy period of `WR_CYCLES` clocks. During that period the select byte gets no acknowledge.
- R11: A read with no address byte returns the byte at the pointer. The pointer is the last written or read address plus one.
- R12: In a read, the pointer increments by one after each byte sent and wraps from 0xFF to 0x00. A master acknowledge asks for the next byte. A master no-acknowledge leaves SDA released until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| strap_ce | input | 3 | Chip-enable straps that the select byte must match |
| wr_ctl | input | 1 | Write control; when high, all writes are refused |

## Verification
The busy countdown of a finished write and the decision on a new select byte can fall in the same cycle. The bench provokes this by ending a byte write with STOP and sending a select byte at once, with `WR_CYCLES` set longer than one byte. That select byte must get no acknowledge, and one sent after the period must get one. A second collision is between a refused data byte and the write-control or protection decision made at the same ninth-clock edge. The bench judges it by reading the location back through the bus and checking that the value is unchanged.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam logic [3:0] TYPE_ARRAY = 4'b1010;
  localparam logic [3:0] TYPE_PROT  = 4'b0110;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEL,
    S_ADDR,
    S_WDATA,
    S_ACK,
    S_RDATA,
    S_RACK
  } slv_state_t;
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sy, sda_sy;
  logic scl_d, sda_d, scl_lvl;

  // synchronizer chain, one flop per stage
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sy[g] <= 1'b1;
          sda_sy[g] <= 1'b1;
        end else if (g == 0) begin
          scl_sy[g] <= scl_in;
          sda_sy[g] <= sda_in;
        end else begin
          scl_sy[g] <= scl_sy[(g == 0) ? 0 : g-1];
          sda_sy[g] <= sda_sy[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign scl_lvl = scl_sy[STAGES-1];
  assign sda_lvl = sda_sy[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_lvl;
      sda_d <= sda_lvl;
    end
  end

  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eeprom_wr_timer.sv
module eeprom_wr_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         left <= '0;
    else if (kick)      left <= CW'(CYCLES);
    else if (left != 0) left <= left - 1'b1;
  end

  assign busy = (left != 0);
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eeprom_pkg::*;
#(
  parameter int WR_CYCLES   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_ce,
  input  logic       wr_ctl
);
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int RW = AW - 4;   // width of the row-offset field (4 bits)

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  slv_state_t state, after_ack;
  logic [DW-1:0] shreg, prot, mem_rdata, rd_byte;
  logic [AW-1:0] ptr;
  logic [3:0] cnt;
  logic tgt_prot, wrote, m_ack, oe_q;
  logic busy, mem_we, prot_we, byte_done, row_locked, wr_ok, sel_hit, sel_prot;

  i2c_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
    .sda_lvl(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eeprom_array #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(ptr), .wdata(shreg),
    .raddr(ptr), .rdata(mem_rdata)
  );

  eeprom_wr_timer #(.CYCLES(WR_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .kick(stop_det & wrote), .busy(busy)
  );

  // Decisions taken at the falling SCL edge that follows the 8th bit
  assign byte_done  = scl_fall && (cnt == 4'd8) && !start_det && !stop_det;
  assign row_locked = prot[7] && (ptr[AW-1:RW] >= prot[RW-1:0]);
  assign wr_ok      = !wr_ctl && (tgt_prot || !row_locked);
  assign sel_prot   = (shreg[7:4] == TYPE_PROT);
  assign sel_hit    = ((shreg[7:4] == TYPE_ARRAY) || sel_prot) &&
                      (shreg[3:1] == strap_ce) && !busy;
  assign mem_we     = (state == S_WDATA) && byte_done && wr_ok && !tgt_prot;
  assign prot_we    = (state == S_WDATA) && byte_done && wr_ok && tgt_prot;
  assign rd_byte    = tgt_prot ? prot : mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prot <= '0;
    else if (prot_we) prot <= shreg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      after_ack <= S_IDLE;
      shreg     <= '0;
      ptr       <= '0;
      cnt       <= '0;
      tgt_prot  <= 1'b0;
      wrote     <= 1'b0;
      m_ack     <= 1'b0;
      oe_q      <= 1'b0;
    end else if (start_det) begin
      state <= S_SEL;
      cnt   <= '0;
      oe_q  <= 1'b0;
    end else if (stop_det) begin
      state <= S_IDLE;
      cnt   <= '0;
      oe_q  <= 1'b0;
      wrote <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: ;
        S_SEL, S_ADDR, S_WDATA: begin
          if (scl_rise && cnt < 4'd8) begin
            shreg <= {shreg[DW-2:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (byte_done) begin
            cnt <= '0;
            if (state == S_SEL) begin
              if (sel_hit) begin
                tgt_prot  <= sel_prot;
                oe_q      <= 1'b1;
                state     <= S_ACK;
                after_ack <= shreg[0] ? S_RDATA : (sel_prot ? S_WDATA : S_ADDR);
              end else begin
                state <= S_IDLE;
              end
            end else if (state == S_ADDR) begin
              ptr       <= shreg;
              oe_q      <= 1'b1;
              state     <= S_ACK;
              after_ack <= S_WDATA;
            end else begin
              if (wr_ok) begin
                oe_q      <= 1'b1;
                state     <= S_ACK;
                after_ack <= S_WDATA;
                wrote     <= 1'b1;
                if (!tgt_prot)
                  ptr <= {ptr[AW-1:RW], ptr[RW-1:0] + 1'b1};
              end else begin
                state <= S_IDLE;
              end
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            cnt   <= '0;
            state <= after_ack;
            if (after_ack == S_RDATA) begin
              shreg <= rd_byte;
              oe_q  <= ~rd_byte[DW-1];
            end else begin
              oe_q  <= 1'b0;
            end
          end
        end
        S_RDATA: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              oe_q  <= 1'b0;
              cnt   <= '0;
              state <= S_RACK;
              if (!tgt_prot) ptr <= ptr + 1'b1;
            end else begin
              shreg <= {shreg[DW-2:0], 1'b0};
              oe_q  <= ~shreg[DW-2];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (m_ack) begin
              shreg <= rd_byte;
              oe_q  <= ~rd_byte[DW-1];
              state <= S_RDATA;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/eeprom_i2c_checker.sv
module eeprom_i2c_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       busy,
  input logic       mem_we,
  input logic       prot_we,
  input logic       wr_ctl,
  input logic [7:0] ptr
);
  // R1: reset forces the line released
  a_r1_reset_release: assert property (@(posedge clk) !rst_n |=> !sda_oe);

  // R4: the pad enable only moves while SCL is low
  a_r4_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R10: nothing is driven during the write cycle
  a_r10_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R8: no store of any kind while write control is high
  a_r8_no_store_wc: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || prot_we) |-> !wr_ctl);

  // R6: a stored byte keeps the pointer within its row
  a_r6_row_kept: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> ptr[7:4] == $past(ptr[7:4]));
endmodule

bind eeprom_i2c_slave eeprom_i2c_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .busy(busy),
  .mem_we(mem_we), .prot_we(prot_we), .wr_ctl(wr_ctl), .ptr(ptr)
);

// File: tb/eeprom_i2c_slave_bench.sv
module eeprom_i2c_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;            // system clocks per quarter SCL period
  localparam int WRC = 600;        // longer than one byte on the bus

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'd0;
  logic wr_ctl = 1'b0;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_i2c_slave #(.WR_CYCLES(WRC)) u_eeprom_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_ce(strap), .wr_ctl(wr_ctl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qtr();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; qtr(); scl_m = 1; qtr(); sda_m = 0; qtr(); scl_m = 0; qtr();
  endtask

  task automatic bus_stop();
    sda_m = 0; qtr(); scl_m = 1; qtr(); sda_m = 1; qtr(); qtr();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qtr(); scl_m = 1; qtr(); qtr(); scl_m = 0; qtr();
    end
    sda_m = 1; qtr(); scl_m = 1; qtr(); ack = ~sda_line; qtr(); scl_m = 0; qtr();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; qtr(); scl_m = 1; qtr(); b[i] = sda_line; qtr(); scl_m = 0; qtr();
    end
    sda_m = ~give_ack; qtr(); scl_m = 1; qtr(); qtr(); scl_m = 0; qtr(); sda_m = 1;
  endtask

  function automatic logic [7:0] sel(input logic [3:0] t, input logic rd);
    return {t, strap, rd};
  endfunction

  task automatic wait_wc();
    repeat (WRC + 20) @(negedge clk);
  endtask

  // write n bytes starting at addr; data d0 + 13*i; each acked iff ok
  task automatic wr_bytes(input logic [7:0] addr, input int n, input logic [7:0] d0,
                          input bit ok, input string req);
    bit a;
    logic [7:0] p, d;
    p = addr;
    bus_start();
    send_byte(sel(4'b1010, 0), a); chk(a, req, a, 1);
    send_byte(addr, a);            chk(a, req, a, 1);
    for (int i = 0; i < n; i++) begin
      d = d0 + 8'(13 * i);
      send_byte(d, a); chk(a == ok, req, a, ok);
      if (ok) begin
        exp_mem[p] = d;
        p = {p[7:4], p[3:0] + 4'd1};
      end
    end
    bus_stop();
    if (ok) wait_wc();
  endtask

  task automatic rd_rand(input logic [7:0] addr, input int n, input string req);
    bit a;
    logic [7:0] v;
    bus_start();
    send_byte(sel(4'b1010, 0), a); chk(a, req, a, 1);
    send_byte(addr, a);            chk(a, req, a, 1);
    bus_start();
    send_byte(sel(4'b1010, 1), a); chk(a, req, a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n-1, v);
      chk(v == exp_mem[8'(addr + i)], req, v, exp_mem[8'(addr + i)]);
    end
    bus_stop();
  endtask

  task automatic rd_cur(input logic [7:0] expv, input string req);
    bit a;
    logic [7:0] v;
    bus_start();
    send_byte(sel(4'b1010, 1), a); chk(a, req, a, 1);
    recv_byte(0, v);
    chk(v == expv, req, v, expv);
    chk(sda_oe == 0, req, sda_oe, 0);   // R12: released after master NoAck
    bus_stop();
  endtask

  initial begin
    bit a;
    logic [7:0] v;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 0, "R1", sda_oe, 0);

    // R3 sweep: every strap against every chip-enable code and three type codes
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 8; c++) begin
        for (int t = 0; t < 3; t++) begin
          logic [3:0] ty;
          bit expa;
          strap = 3'(s);
          ty = (t == 0) ? 4'b1010 : (t == 1) ? 4'b0110 : 4'b1011;
          if (t == 2 && c != s) continue;
          expa = (c == s) && (t != 2);
          bus_start();
          send_byte({ty, 3'(c), 1'b0}, a);
          chk(a == expa, "R3", a, expa);
          bus_stop();
        end
      end
    end
    strap = 3'b101;

    // R1/R11: pointer starts at 0, array cleared
    rd_cur(8'h00, "R11");

    // R5 byte write, R7 random read
    wr_bytes(8'h20, 1, 8'hA5, 1, "R5");
    rd_rand(8'h20, 1, "R7");

    // R10: select right after a stored write is refused, later accepted
    wr_bytes(8'h21, 1, 8'h3C, 1, "R10");   // waits inside; redo without wait below
    bus_start(); send_byte(sel(4'b1010, 0), a); send_byte(8'h22, a);
    send_byte(8'h5E, a); bus_stop();
    exp_mem[8'h22] = 8'h5E;
    bus_start(); send_byte(sel(4'b1010, 0), a);
    chk(a == 0, "R10", a, 0);
    bus_stop();
    wait_wc();
    bus_start(); send_byte(sel(4'b1010, 0), a);
    chk(a == 1, "R10", a, 1);
    bus_stop();

    // R6 page write crossing the row end wraps inside the row
    wr_bytes(8'h3A, 16, 8'h11, 1, "R6");
    rd_rand(8'h30, 16, "R6");
    // after the page, pointer 0x3A then read of 16 left it at 0x40
    rd_cur(exp_mem[8'h40], "R11");

    // R12 sequential read wraps 0xFF -> 0x00
    wr_bytes(8'hFF, 1, 8'h77, 1, "R12");
    wr_bytes(8'h00, 1, 8'h19, 1, "R12");
    rd_rand(8'hFF, 3, "R12");
    rd_cur(exp_mem[8'h02], "R11");

    // R8 write control refuses data; no busy period follows
    wr_ctl = 1;
    wr_bytes(8'h50, 1, 8'h99, 0, "R8");
    wr_ctl = 0;
    rd_rand(8'h50, 1, "R8");

    // R9 protection register: write, read back, then enforce
    bus_start(); send_byte(sel(4'b0110, 0), a); chk(a, "R9", a, 1);
    send_byte(8'h86, a); chk(a, "R9", a, 1); bus_stop();
    wait_wc();
    bus_start(); send_byte(sel(4'b0110, 1), a); chk(a, "R9", a, 1);
    recv_byte(0, v); chk(v == 8'h86, "R9", v, 8'h86); bus_stop();
    wr_bytes(8'h70, 1, 8'h42, 0, "R9");
    rd_rand(8'h70, 1, "R9");
    wr_bytes(8'h5F, 1, 8'h42, 1, "R9");
    rd_rand(8'h5F, 1, "R9");
    wr_bytes(8'h60, 1, 8'h24, 0, "R9");
    rd_rand(8'h60, 1, "R9");

    // R2: START mid-byte aborts; a fresh select is still decoded
    bus_start();
    sda_m = 1; qtr(); scl_m = 1; qtr(); qtr(); scl_m = 0; qtr();
    bus_start(); send_byte(sel(4'b1010, 0), a); chk(a, "R2", a, 1);
    bus_stop();

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule